// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block sits between a host processor and the command engine of a disk controller. The host reaches eight byte-wide registers through a 3-bit register address, a chip select and separate read and write enables. The bidirectional data bus is split into an input byte, an output byte and an output-enable that drives the pad only during a selected read. A byte-wide data window feeds a small internal sector buffer. The other six registers hold the transfer parameters. The top slot is write-only for commands and read-only for status.

Slow buffer accesses are stretched with a WAIT line. A configuration pin chooses whether WAIT may rise on chip select alone or only once a read or write enable qualifies it. The block raises an interrupt request when a command finishes. It raises a data request for each byte the buffer holds for the host or expects from it. The ordering of the two depends on a DMA bit in the read command. A one-cycle `cmd_done` input stands in for the execution engine.

Command opcodes sit in the upper nibble of the command byte: restore `1`, read sector `2`, write sector `3`, seek `7`. Bit 3 of a read command is the DMA bit. The status byte has busy at bit 7, drive ready (always 1) at bit 6 and data request at bit 3, and every other bit reads 0. Register slots are: 0 data window, 1 write-precompensation cylinder, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 size/drive/head, 7 command/status.

Top module: `hti_taskfile`

## Requirements
- R1: `dat_oe` is 1 only while `sel` and `rd_en` are both 1. A read of slots 1 to 6 returns the byte last written there.
- R2: While `rst_n` is 0, and until the first write afterwards, the registers read back as: sector number, both cylinder bytes and size/drive/head 0; sector count 1; precompensation cylinder 128; status 0x40; `step_rate` 15 (the 7.5 ms code). `drq` is 0 and `irq` is 1.
- R3: A data-window access made when the buffer is ready completes with `wait_o` low. Each data-window access leaves the buffer not ready for `BUF_LAT` cycles. An access in that window holds `wait_o` high until it completes.
- R4: With `early_wait`=1, `wait_o` may rise on `sel` alone. With `early_wait`=0 it rises only while `rd_en` or `wr_en` is also 1.
- R5: `irq` rises on `cmd_done` for a busy command. It clears on a status read and on an accepted command write.
- R6: Status bit 7 is 1 from an accepted command until `cmd_done`. A command write during that time is ignored: no `cmd_go`, and `step_rate` is unchanged.
- R7: On a read sector with the DMA bit 0, `irq` rises one cycle before the first `drq`. With the DMA bit 1, `drq` rises while `irq` stays 0, and `irq` rises only when the last buffer byte is read.
- R8: `drq` falls after every data-window access. It rises again while bytes remain, and stays 0 once `BUF_BYTES` bytes have moved.
- R9: An access to the cylinder-low slot during a transfer ends it, and `drq` stays 0.
- R10: Bytes written during a write sector are returned in the same order by a later read sector.
- R11: `step_rate` loads the low nibble of a restore or seek command. Other opcodes leave it unchanged.
- R12: One assertion of a strobe performs one access, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| early_wait | input | 1 | 1: WAIT may assert on chip select alone |
| sel | input | 1 | Chip select |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| addr | input | 3 | Register slot |
| dat_i | input | 8 | Host write byte |
| dat_o | output | 8 | Host read byte |
| dat_oe | output | 1 | Bus drive enable |
| wait_o | output | 1 | Host stall request |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | Data request |
| cmd_done | input | 1 | Completion pulse from the command engine |
| cmd_go | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 8 | Last accepted command byte |
| step_rate | output | 4 | Step rate code |

## Verification
The properties assume the host never raises `rd_en` and `wr_en` together. They also assume `addr` and `dat_i` hold steady while a strobe is up, and that each strobe drops for at least one cycle before the next access. The bench uses one read task and one write task that change inputs only on falling edges and keep the address fixed until the strobe falls. Those tasks poll `wait_o` before letting an access finish.

// File: rtl/hti_pkg.sv
package hti_pkg;
  localparam logic [2:0] RA_DATA    = 3'd0;
  localparam logic [2:0] RA_PRECOMP = 3'd1;
  localparam logic [2:0] RA_COUNT   = 3'd2;
  localparam logic [2:0] RA_CYL_LO  = 3'd4;
  localparam logic [2:0] RA_CMD     = 3'd7;

  localparam logic [3:0] OP_RESTORE = 4'h1;
  localparam logic [3:0] OP_READ    = 4'h2;
  localparam logic [3:0] OP_WRITE   = 4'h3;
  localparam logic [3:0] OP_SEEK    = 4'h7;
  localparam int         DMA_BIT    = 3;

  localparam int ST_BUSY  = 7;
  localparam int ST_READY = 6;
  localparam int ST_DRQ   = 3;

  typedef enum logic [1:0] {XF_IDLE, XF_TO_HOST, XF_FROM_HOST} xfer_e;
endpackage

// File: rtl/hti_access.sv
module hti_access
  import hti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       early_wait,
  input  logic       sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic       buf_ready,
  output logic       wait_o,
  output logic       rd_fire,
  output logic       wr_fire
);
  logic strobe, held_q, can_go, fire, qual;

  always_comb begin
    strobe  = sel & (rd_en | wr_en);
    can_go  = (addr != RA_DATA) | buf_ready;
    fire    = strobe & ~held_q & can_go;
    rd_fire = fire & rd_en;
    wr_fire = fire & ~rd_en & wr_en;
    qual    = early_wait ? sel : strobe;
    wait_o  = qual & ~held_q & ~can_go;
  end

  // one access per strobe: hold until the strobe drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (fire)    held_q <= 1'b1;
    else if (!strobe) held_q <= 1'b0;
  end
endmodule

// File: rtl/hti_regs.sv
module hti_regs
  import hti_pkg::*;
#(
  parameter logic [7:0] PRECOMP_RST = 8'd128,
  parameter logic [3:0] STEP_RST    = 4'd15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       cmd_accept,
  input  logic [2:0] addr,
  input  logic [7:0] dat_i,
  input  logic [7:0] buf_rdata,
  input  logic       busy,
  input  logic       drq,
  output logic [7:0] rd_data,
  output logic [3:0] step_rate
);
  localparam int NSLOT = 6;

  logic [7:0] tf_q [1:NSLOT];
  logic [7:0] status;

  function automatic logic [7:0] slot_reset(input int s);
    case (s)
      int'(RA_PRECOMP): slot_reset = PRECOMP_RST;
      int'(RA_COUNT):   slot_reset = 8'd1;
      default:          slot_reset = 8'd0;
    endcase
  endfunction

  for (genvar g = 1; g <= NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tf_q[g] <= slot_reset(g);
      else if (wr_fire && addr == 3'(g)) tf_q[g] <= dat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_rate <= STEP_RST;
    else if (cmd_accept && (dat_i[7:4] == OP_RESTORE || dat_i[7:4] == OP_SEEK))
      step_rate <= dat_i[3:0];
  end

  always_comb begin
    status           = 8'h00;
    status[ST_BUSY]  = busy;
    status[ST_READY] = 1'b1;
    status[ST_DRQ]   = drq;
    case (addr)
      RA_DATA: rd_data = buf_rdata;
      RA_CMD:  rd_data = status;
      default: rd_data = tf_q[addr];
    endcase
  end
endmodule

// File: rtl/hti_xfer.sv
module hti_xfer
  import hti_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int BUF_LAT   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_fire,
  input  logic       wr_fire,
  input  logic [2:0] addr,
  input  logic [7:0] dat_i,
  input  logic       cmd_accept,
  input  logic       cmd_done,
  output logic       busy,
  output logic       irq,
  output logic       drq,
  output logic       buf_ready,
  output logic [7:0] buf_rdata,
  output logic       cmd_go,
  output logic [7:0] cmd_code
);
  localparam int PW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam int LW = $clog2(BUF_LAT + 2);

  logic [7:0]    mem_q [BUF_BYTES];
  logic [PW-1:0] ptr_q;
  logic [LW-1:0] rdy_q;
  logic [3:0]    op_q;
  logic          dma_q;
  xfer_e         mode_q;
  logic          data_acc, cyl_acc, stat_rd, last;

  always_comb begin
    data_acc  = (rd_fire | wr_fire) && addr == RA_DATA;
    cyl_acc   = (rd_fire | wr_fire) && addr == RA_CYL_LO;
    stat_rd   = rd_fire && addr == RA_CMD;
    last      = ptr_q == PW'(BUF_BYTES - 1);
    buf_ready = rdy_q == '0;
    buf_rdata = mem_q[ptr_q];
  end

  always_ff @(posedge clk) begin
    if (wr_fire && addr == RA_DATA && mode_q == XF_FROM_HOST) mem_q[ptr_q] <= dat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; irq <= 1'b1; drq <= 1'b0; mode_q <= XF_IDLE;
      dma_q <= 1'b0; op_q <= '0; ptr_q <= '0; rdy_q <= '0;
      cmd_go <= 1'b0; cmd_code <= '0;
    end else begin
      cmd_go <= 1'b0;
      if (rdy_q != '0) rdy_q <= rdy_q - 1'b1;
      if (stat_rd) irq <= 1'b0;
      if (cmd_accept) begin
        busy <= 1'b1; irq <= 1'b0; drq <= 1'b0; ptr_q <= '0;
        op_q <= dat_i[7:4]; dma_q <= dat_i[DMA_BIT];
        cmd_go <= 1'b1; cmd_code <= dat_i;
        mode_q <= (dat_i[7:4] == OP_WRITE) ? XF_FROM_HOST : XF_IDLE;
      end else begin
        if (busy && cmd_done) begin
          busy <= 1'b0;
          if (op_q == OP_READ) begin
            mode_q <= XF_TO_HOST;
            ptr_q  <= '0;
            if (!dma_q) irq <= 1'b1;
          end else begin
            mode_q <= XF_IDLE;
            irq    <= 1'b1;
          end
        end
        if (data_acc) begin
          rdy_q <= LW'(BUF_LAT);
          drq   <= 1'b0;
          if (mode_q != XF_IDLE) begin
            ptr_q <= ptr_q + 1'b1;
            if (last) begin
              mode_q <= XF_IDLE;
              ptr_q  <= '0;
              if (mode_q == XF_TO_HOST && dma_q) irq <= 1'b1;
            end
          end
        end else if (cyl_acc && mode_q != XF_IDLE) begin
          mode_q <= XF_IDLE;
          drq    <= 1'b0;
        end else if (mode_q != XF_IDLE && !drq && rdy_q == '0) begin
          drq <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hti_taskfile.sv
module hti_taskfile
  import hti_pkg::*;
#(
  parameter int         BUF_BYTES   = 8,
  parameter int         BUF_LAT     = 2,
  parameter logic [7:0] PRECOMP_RST = 8'd128,
  parameter logic [3:0] STEP_RST    = 4'd15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       early_wait,
  input  logic       sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] dat_i,
  output logic [7:0] dat_o,
  output logic       dat_oe,
  output logic       wait_o,
  output logic       irq,
  output logic       drq,
  input  logic       cmd_done,
  output logic       cmd_go,
  output logic [7:0] cmd_code,
  output logic [3:0] step_rate
);
  logic rd_fire_w, wr_fire_w, busy_w, buf_ready_w, cmd_accept_w;
  logic [7:0] buf_rdata_w;

  assign cmd_accept_w = wr_fire_w && addr == RA_CMD && !busy_w;
  assign dat_oe       = sel & rd_en;

  hti_access u_access (
    .clk, .rst_n, .early_wait, .sel, .rd_en, .wr_en, .addr,
    .buf_ready(buf_ready_w), .wait_o, .rd_fire(rd_fire_w), .wr_fire(wr_fire_w)
  );

  hti_regs #(.PRECOMP_RST(PRECOMP_RST), .STEP_RST(STEP_RST)) u_regs (
    .clk, .rst_n, .wr_fire(wr_fire_w), .cmd_accept(cmd_accept_w), .addr, .dat_i,
    .buf_rdata(buf_rdata_w), .busy(busy_w), .drq, .rd_data(dat_o), .step_rate
  );

  hti_xfer #(.BUF_BYTES(BUF_BYTES), .BUF_LAT(BUF_LAT)) u_xfer (
    .clk, .rst_n, .rd_fire(rd_fire_w), .wr_fire(wr_fire_w), .addr, .dat_i,
    .cmd_accept(cmd_accept_w), .cmd_done, .busy(busy_w), .irq, .drq,
    .buf_ready(buf_ready_w), .buf_rdata(buf_rdata_w), .cmd_go, .cmd_code
  );
endmodule

// File: rtl/hti_taskfile_chk.sv
module hti_taskfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       early_wait,
  input logic       sel,
  input logic       rd_en,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic       wait_o,
  input logic       irq,
  input logic       drq,
  input logic       cmd_go,
  input logic       busy,
  input logic       rd_fire,
  input logic       wr_fire
);
  AST_WAIT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> sel); // R4
  AST_LATE_WAIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_wait && wait_o) |-> (rd_en || wr_en)); // R4
  AST_NO_FIRE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !(rd_fire || wr_fire)); // R3
  AST_ONE_ACCESS_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire || wr_fire) |=> !(rd_fire || wr_fire)); // R12
  AST_GO_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !$past(busy)); // R6
  AST_GO_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !irq); // R5
  AST_DRQ_DROPS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_fire || wr_fire) && addr == 3'd0) |=> !drq); // R8
endmodule

bind hti_taskfile hti_taskfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .early_wait(early_wait), .sel(sel), .rd_en(rd_en),
  .wr_en(wr_en), .addr(addr), .wait_o(wait_o), .irq(irq), .drq(drq),
  .cmd_go(cmd_go), .busy(busy_w), .rd_fire(rd_fire_w), .wr_fire(wr_fire_w)
);

// File: tb/tb_hti_taskfile.sv
`timescale 1ns/1ps
module tb_hti_taskfile;
  localparam int BUF_BYTES = 8;
  localparam int BUF_LAT   = 2;
  localparam int NV        = 8;
  // {slot, write byte, expected readback}
  localparam logic [18:0] VEC [NV] = '{
    {3'd1, 8'h5A, 8'h5A}, {3'd2, 8'h03, 8'h03}, {3'd3, 8'h11, 8'h11},
    {3'd4, 8'hC4, 8'hC4}, {3'd5, 8'h02, 8'h02}, {3'd6, 8'hA5, 8'hA5},
    {3'd1, 8'hFF, 8'hFF}, {3'd3, 8'h00, 8'h00}};

  logic clk = 0, rst_n = 0, early_wait = 0, sel = 0, rd_en = 0, wr_en = 0, cmd_done = 0;
  logic [2:0] addr = '0;
  logic [7:0] dat_i = '0;
  logic [7:0] dat_o, cmd_code;
  logic dat_oe, wait_o, irq, drq, cmd_go;
  logic [3:0] step_rate;
  int checks = 0, fails = 0;
  logic [7:0] rd;
  int w, first_irq, first_drq;

  always #2.5 clk = ~clk;

  hti_taskfile #(.BUF_BYTES(BUF_BYTES), .BUF_LAT(BUF_LAT)) dut (
    .clk, .rst_n, .early_wait, .sel, .rd_en, .wr_en, .addr, .dat_i, .dat_o,
    .dat_oe, .wait_o, .irq, .drq, .cmd_done, .cmd_go, .cmd_code, .step_rate);

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_rd(input logic [2:0] a, input int hold, output logic [7:0] d, output int waits);
    @(negedge clk); addr = a; sel = 1; rd_en = 1; waits = 0;
    #1;
    while (wait_o) begin waits++; @(negedge clk); #1; end
    d = dat_o;
    chk("R1 drive", int'(dat_oe), 1);
    repeat (hold) @(negedge clk);
    @(negedge clk); sel = 0; rd_en = 0;
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dat_i = d; sel = 1; wr_en = 1;
    #1;
    while (wait_o) begin @(negedge clk); #1; end
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  task automatic wait_drq();
    for (int n = 0; n < 100 && !drq; n++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // reset state, R2
    repeat (3) @(negedge clk);
    chk("R2 irq", int'(irq), 1);
    chk("R2 drq", int'(drq), 0);
    chk("R2 step", int'(step_rate), 15);
    chk("R1 idle oe", int'(dat_oe), 0);
    rst_n = 1;
    host_rd(3'd1, 0, rd, w); chk("R2 precomp", int'(rd), 128);
    host_rd(3'd2, 0, rd, w); chk("R2 count", int'(rd), 1);
    for (int s = 3; s <= 6; s++) begin
      host_rd(3'(s), 0, rd, w); chk("R2 zero slot", int'(rd), 0);
    end
    host_rd(3'd7, 0, rd, w); chk("R2 status", int'(rd), 8'h40);
    chk("R5 status read clears irq", int'(irq), 0);

    // R1: table of write/readback vectors
    for (int v = 0; v < NV; v++) begin
      host_wr(VEC[v][18:16], VEC[v][15:8]);
      host_rd(VEC[v][18:16], 0, rd, w);
      chk("R1 readback", int'(rd), int'(VEC[v][7:0]));
    end
    @(negedge clk); rd_en = 1; #1;
    chk("R1 no drive without sel", int'(dat_oe), 0);
    rd_en = 0;

    // R11, R6, R5
    host_wr(3'd7, 8'h13);
    chk("R11 restore loads step", int'(step_rate), 3);
    host_rd(3'd7, 0, rd, w); chk("R6 busy bit", int'(rd[7]), 1);
    host_wr(3'd7, 8'h75);
    chk("R6 busy write ignored", int'(step_rate), 3);
    chk("R6 code kept", int'(cmd_code), 8'h13);
    pulse_done();
    chk("R5 irq on done", int'(irq), 1);
    host_rd(3'd7, 0, rd, w); chk("R6 busy clear", int'(rd[7]), 0);
    host_wr(3'd7, 8'h7C);
    chk("R11 seek loads step", int'(step_rate), 12);
    pulse_done();
    chk("R5 irq on seek done", int'(irq), 1);

    // write sector: R5, R11, R8, R10
    host_wr(3'd7, 8'h34);
    chk("R5 command clears irq", int'(irq), 0);
    chk("R11 write opcode keeps step", int'(step_rate), 12);
    for (int i = 0; i < BUF_BYTES; i++) begin
      wait_drq();
      chk("R8 drq up", int'(drq), 1);
      host_wr(3'd0, pat(i));
      chk("R8 drq down after access", int'(drq), 0);
    end
    repeat (6) @(negedge clk);
    chk("R8 drq stays low after buffer", int'(drq), 0);
    pulse_done();
    host_rd(3'd7, 0, rd, w);

    // read sector, no DMA: R7, R3, R12, R10
    host_wr(3'd7, 8'h20);
    first_irq = -1; first_drq = -1;
    @(negedge clk); cmd_done = 1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); cmd_done = 0;
      if (irq && first_irq < 0) first_irq = c;
      if (drq && first_drq < 0) first_drq = c;
    end
    chk("R7 irq cycle", first_irq, 0);
    chk("R7 drq one cycle later", first_drq, 1);
    host_rd(3'd0, 0, rd, w);
    chk("R3 no wait when ready", w, 0);
    chk("R10 byte 0", int'(rd), int'(pat(0)));
    host_rd(3'd0, 0, rd, w);
    chk("R3 stall when not ready", int'(w >= 1 && w <= BUF_LAT), 1);
    chk("R10 byte 1", int'(rd), int'(pat(1)));
    wait_drq();
    host_rd(3'd0, 4, rd, w);
    chk("R10 byte 2", int'(rd), int'(pat(2)));
    for (int i = 3; i < BUF_BYTES; i++) begin
      wait_drq();
      host_rd(3'd0, 0, rd, w);
      chk(i == 3 ? "R12 held strobe is one access" : "R10 byte", int'(rd), int'(pat(i)));
    end
    repeat (6) @(negedge clk);
    chk("R8 read exhausted", int'(drq), 0);
    host_rd(3'd7, 0, rd, w);

    // read sector with DMA bit: R7
    host_wr(3'd7, 8'h28);
    pulse_done();
    wait_drq();
    chk("R7 dma drq without irq", int'(irq), 0);
    for (int i = 0; i < BUF_BYTES; i++) begin
      wait_drq();
      if (i == BUF_BYTES - 1) chk("R7 irq still low before last", int'(irq), 0);
      host_rd(3'd0, 0, rd, w);
      chk("R10 dma byte", int'(rd), int'(pat(i)));
    end
    chk("R7 dma irq after last byte", int'(irq), 1);
    host_rd(3'd7, 0, rd, w);

    // cylinder-low access ends transfer: R9
    host_wr(3'd7, 8'h20);
    pulse_done();
    for (int i = 0; i < 2; i++) begin wait_drq(); host_rd(3'd0, 0, rd, w); end
    host_rd(3'd4, 0, rd, w);
    repeat (10) @(negedge clk);
    chk("R9 transfer ended", int'(drq), 0);

    // WAIT mode: R4
    early_wait = 1;
    host_rd(3'd0, 0, rd, w);
    @(negedge clk); addr = 3'd0; sel = 1; #1;
    chk("R4 early wait on select", int'(wait_o), 1);
    @(negedge clk); sel = 0;
    repeat (4) @(negedge clk);
    early_wait = 0;
    host_rd(3'd0, 0, rd, w);
    @(negedge clk); addr = 3'd0; sel = 1; #1;
    chk("R4 late mode no wait on select", int'(wait_o), 0);
    rd_en = 1; #0.5;
    chk("R4 late mode wait on strobe", int'(wait_o), 1);
    repeat (3) @(negedge clk);
    sel = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule